// File: doc/BRIEF.md
# Snooping Bloom Filter

This block keeps an approximate set of 32-bit keys in a bit vector, next to one processor core. The core reaches it through a command port. A command can add a key, ask whether a key may be in the set, empty the set, or choose which of the core's memory requests are learned automatically. A snoop port sees the same core's memory request stream. When the snoop mode allows it, the block adds the address of each matching request to the set, and the core does not have to act.

Each of the k hash functions multiplies the key by its own fixed prime. Index i is the upper log2(NUM_BITS) bits of the low 32 bits of that product. Multiplying by a constant lets synthesis build each hash from shifts and adders. A search answers "maybe present" only when all k indexed bits are set. Otherwise it answers "definitely absent".

Command control is a two-state machine. `CMD_IDLE` is the state when no answer is owed. `CMD_ANSWER` is the state in the cycle after a search, and it drives the response. The machine takes the transition `IDLE->ANSWER` or `ANSWER->ANSWER` when a search command is accepted. It takes `ANSWER->IDLE` or `IDLE->IDLE` in every other cycle.

Top module: `snoop_bloom_top`

## Requirements
- R1: After reset the bit vector is empty, the snoop mode is off (code 00), and `rsp_valid` is 0.
- R2: Hash h (h = 0..NUM_HASH-1, at most 8) sets or tests bit `(key * P[h]) mod 2^32 >> (32 - log2(NUM_BITS))`. P = 0x9E3779B1, 0x85EBCA77, 0xC2B2AE3D, 0x27D4EB2F, 0x165667B1, 0x01000193, 0x3B9ACA07, 0x3B800001. NUM_BITS is a power of two.
- R3: A command with `cmd_op` = 00 (insert) sets all k indexed bits of `cmd_key`. Bits are only ever cleared by a clear command.
- R4: A command with `cmd_op` = 01 (search) causes `rsp_valid` to be 1 for exactly the next cycle. In that cycle `rsp_maybe` is 1 if and only if all k indexed bits of `cmd_key` were set.
- R5: A command with `cmd_op` = 10 (clear) empties the whole bit vector in one cycle.
- R6: A command with `cmd_op` = 11 (configure) loads the snoop mode from `cmd_key[1:0]`: 00 off, 01 reads only, 10 writes only, 11 both. The new mode applies from the next cycle.
- R7: A snoop request (`snp_valid` = 1) is inserted only if its type matches the mode. `snp_write` = 0 marks a read and 1 marks a write. Requests that do not match leave the vector unchanged.
- R8: A command insert and a snooped insert in the same cycle are both applied.
- R9: A search in the same cycle as a snooped insert of the same key answers from the vector as it was before that insert.
- R10: A clear in the same cycle as a snooped insert wins, and the vector is left empty.
- R11: `cmd_ready` is 1 in every cycle, so every command is accepted when offered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | 00 insert, 01 search, 10 clear, 11 configure |
| cmd_key | input | 32 | Key; bits [1:0] carry the mode for configure |
| cmd_ready | output | 1 | Command accepted (always 1) |
| snp_valid | input | 1 | Memory request seen on the core's bus |
| snp_write | input | 1 | 1 for a write request, 0 for a read |
| snp_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Search answer is valid |
| rsp_maybe | output | 1 | 1 maybe present, 0 definitely absent |

## Verification
The search answer is the only visible result. It is due one clock edge after the search is accepted. The state of the vector and the snoop mode can only be seen through later searches, which also answer one edge later. The driver applies each command at a falling edge and pushes the expected answer, taken from a bench-side model of the vector, into a queue. The monitor samples `rsp_valid` and `rsp_maybe` at the following falling edge, pops the queue there, and flags any answer that appears without a matching entry.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

    typedef enum logic [1:0] {
        OP_INSERT = 2'b00,
        OP_SEARCH = 2'b01,
        OP_CLEAR  = 2'b10,
        OP_CONFIG = 2'b11
    } sbf_op_e;

    typedef enum logic [1:0] {
        SNOOP_OFF = 2'b00,
        SNOOP_RD  = 2'b01,
        SNOOP_WR  = 2'b10,
        SNOOP_RW  = 2'b11
    } snoop_mode_e;

    typedef enum logic {
        CMD_IDLE   = 1'b0,
        CMD_ANSWER = 1'b1
    } cmd_state_e;

    localparam int unsigned SBF_MAX_HASH = 8;

    // Odd primes below 2^32; hash h uses entry h.
    function automatic logic [31:0] sbf_prime(input int unsigned h);
        logic [31:0] p;
        case (h)
            0:       p = 32'h9E3779B1;
            1:       p = 32'h85EBCA77;
            2:       p = 32'hC2B2AE3D;
            3:       p = 32'h27D4EB2F;
            4:       p = 32'h165667B1;
            5:       p = 32'h01000193;
            6:       p = 32'h3B9ACA07;
            default: p = 32'h3B800001;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sbf_hash_unit.sv
module sbf_hash_unit #(
    parameter int unsigned KEY_W = 32,
    parameter int unsigned IDX_W = 8,
    parameter logic [31:0] PRIME = 32'h9E3779B1
) (
    input  logic [KEY_W-1:0] key,
    output logic [IDX_W-1:0] idx
);
    // Constant multiplicand: synthesis reduces this to shifts and adders.
    localparam logic [KEY_W-1:0] MULT = KEY_W'(PRIME);

    logic [KEY_W-1:0] product;

    assign product = key * MULT;
    assign idx     = product[KEY_W-1 -: IDX_W];
endmodule

// File: rtl/sbf_mask_gen.sv
module sbf_mask_gen #(
    parameter int unsigned NUM_BITS = 256,
    parameter int unsigned NUM_HASH = 3,
    parameter int unsigned KEY_W    = 32
) (
    input  logic [KEY_W-1:0]    key,
    output logic [NUM_BITS-1:0] mask
);
    import sbf_pkg::*;

    localparam int unsigned IDX_W = $clog2(NUM_BITS);

    logic [IDX_W-1:0] idx [NUM_HASH];

    for (genvar g = 0; g < NUM_HASH; g++) begin : g_hash
        sbf_hash_unit #(
            .KEY_W (KEY_W),
            .IDX_W (IDX_W),
            .PRIME (sbf_prime(g))
        ) hash_i (
            .key (key),
            .idx (idx[g])
        );
    end

    always_comb begin
        mask = '0;
        for (int h = 0; h < NUM_HASH; h++) begin
            mask[idx[h]] = 1'b1;
        end
    end
endmodule

// File: rtl/sbf_bit_array.sv
module sbf_bit_array #(
    parameter int unsigned NUM_BITS = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic [NUM_BITS-1:0] set_a,
    input  logic [NUM_BITS-1:0] set_b,
    output logic [NUM_BITS-1:0] bits
);
    logic [NUM_BITS-1:0] bits_d;

    always_comb begin
        if (clear) begin
            bits_d = '0;
        end else begin
            bits_d = bits | set_a | set_b;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= '0;
        end else begin
            bits <= bits_d;
        end
    end
endmodule

// File: rtl/sbf_cmd_fsm.sv
module sbf_cmd_fsm
    import sbf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic [1:0] mode_field,
    input  logic       hit_now,
    input  logic       snp_valid,
    input  logic       snp_write,
    output logic       rsp_valid,
    output logic       rsp_maybe,
    output logic       do_insert,
    output logic       do_clear,
    output logic       snoop_take
);
    cmd_state_e  state_q, state_d;
    snoop_mode_e mode_q;
    logic        maybe_q;
    sbf_op_e     op;
    logic        is_search;

    assign op        = sbf_op_e'(cmd_op);
    assign is_search = cmd_valid && (op == OP_SEARCH);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CMD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE:   state_d = is_search ? CMD_ANSWER : CMD_IDLE;
            CMD_ANSWER: state_d = is_search ? CMD_ANSWER : CMD_IDLE;
            default:    state_d = CMD_IDLE;
        endcase
    end

    // Data registers: snoop mode and captured search result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= SNOOP_OFF;
            maybe_q <= 1'b0;
        end else begin
            if (cmd_valid && (op == OP_CONFIG)) begin
                mode_q <= snoop_mode_e'(mode_field);
            end
            if (is_search) begin
                maybe_q <= hit_now;
            end
        end
    end

    // Outputs
    always_comb begin
        rsp_valid = (state_q == CMD_ANSWER);
        rsp_maybe = (state_q == CMD_ANSWER) && maybe_q;
        do_insert = cmd_valid && (op == OP_INSERT);
        do_clear  = cmd_valid && (op == OP_CLEAR);
        unique case (mode_q)
            SNOOP_OFF: snoop_take = 1'b0;
            SNOOP_RD:  snoop_take = snp_valid && !snp_write;
            SNOOP_WR:  snoop_take = snp_valid && snp_write;
            SNOOP_RW:  snoop_take = snp_valid;
            default:   snoop_take = 1'b0;
        endcase
    end
endmodule

// File: rtl/snoop_bloom_top.sv
module snoop_bloom_top #(
    parameter int unsigned NUM_BITS = 256,
    parameter int unsigned NUM_HASH = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [31:0] cmd_key,
    output logic        cmd_ready,
    input  logic        snp_valid,
    input  logic        snp_write,
    input  logic [31:0] snp_addr,
    output logic        rsp_valid,
    output logic        rsp_maybe
);
    import sbf_pkg::*;

    localparam int unsigned KEY_W = 32;

    logic [NUM_BITS-1:0] cmd_mask;
    logic [NUM_BITS-1:0] snp_mask;
    logic [NUM_BITS-1:0] array_bits;
    logic [NUM_BITS-1:0] ins_a;
    logic [NUM_BITS-1:0] ins_b;
    logic                hit_now;
    logic                do_insert;
    logic                do_clear;
    logic                snoop_take;

    sbf_mask_gen #(
        .NUM_BITS (NUM_BITS),
        .NUM_HASH (NUM_HASH),
        .KEY_W    (KEY_W)
    ) cmd_hash_i (
        .key  (cmd_key),
        .mask (cmd_mask)
    );

    sbf_mask_gen #(
        .NUM_BITS (NUM_BITS),
        .NUM_HASH (NUM_HASH),
        .KEY_W    (KEY_W)
    ) snp_hash_i (
        .key  (snp_addr),
        .mask (snp_mask)
    );

    sbf_cmd_fsm ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .mode_field (cmd_key[1:0]),
        .hit_now    (hit_now),
        .snp_valid  (snp_valid),
        .snp_write  (snp_write),
        .rsp_valid  (rsp_valid),
        .rsp_maybe  (rsp_maybe),
        .do_insert  (do_insert),
        .do_clear   (do_clear),
        .snoop_take (snoop_take)
    );

    assign ins_a = do_insert  ? cmd_mask : '0;
    assign ins_b = snoop_take ? snp_mask : '0;

    sbf_bit_array #(
        .NUM_BITS (NUM_BITS)
    ) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (do_clear),
        .set_a (ins_a),
        .set_b (ins_b),
        .bits  (array_bits)
    );

    // Searches read the registered vector, i.e. the state before this cycle's inserts.
    assign hit_now   = ((array_bits & cmd_mask) == cmd_mask);
    assign cmd_ready = 1'b1;
endmodule

// File: rtl/sbf_checker.sv
module sbf_checker #(
    parameter int unsigned NUM_BITS = 256,
    parameter int unsigned NUM_HASH = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic [1:0]          cmd_op,
    input logic                rsp_valid,
    input logic [NUM_BITS-1:0] array_bits,
    input logic [NUM_BITS-1:0] cmd_mask,
    input logic [NUM_BITS-1:0] snp_mask,
    input logic                snoop_take
);
    logic srch, clr, ins;
    assign srch = cmd_valid && (cmd_op == 2'b01);
    assign clr  = cmd_valid && (cmd_op == 2'b10);
    assign ins  = cmd_valid && (cmd_op == 2'b00);

    // R4
    search_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srch |=> rsp_valid);

    // R4
    answer_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(srch));

    // R5
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (array_bits == '0));

    // R3
    insert_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins |=> ((array_bits & $past(cmd_mask)) == $past(cmd_mask)));

    // R8
    snoop_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_take && !clr) |=> ((array_bits & $past(snp_mask)) == $past(snp_mask)));

    // R3
    bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((array_bits & $past(array_bits)) == $past(array_bits)));

    // R2
    mask_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cmd_mask) >= 1) && ($countones(cmd_mask) <= NUM_HASH));
endmodule

bind snoop_bloom_top sbf_checker #(
    .NUM_BITS (NUM_BITS),
    .NUM_HASH (NUM_HASH)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .rsp_valid  (rsp_valid),
    .array_bits (array_bits),
    .cmd_mask   (cmd_mask),
    .snp_mask   (snp_mask),
    .snoop_take (snoop_take)
);

// File: tb/snoop_bloom_top_tb_top.sv
module snoop_bloom_top_tb_top;
    localparam int unsigned NB = 256;
    localparam int unsigned NH = 3;
    localparam int unsigned IW = $clog2(NB);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [31:0] cmd_key = '0;
    logic        cmd_ready;
    logic        snp_valid = 1'b0;
    logic        snp_write = 1'b0;
    logic [31:0] snp_addr = '0;
    logic        rsp_valid;
    logic        rsp_maybe;

    always #5 clk = ~clk;

    snoop_bloom_top #(.NUM_BITS(NB), .NUM_HASH(NH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_key(cmd_key), .cmd_ready(cmd_ready), .snp_valid(snp_valid),
        .snp_write(snp_write), .snp_addr(snp_addr), .rsp_valid(rsp_valid),
        .rsp_maybe(rsp_maybe)
    );

    typedef struct {
        bit    maybe;
        string req;
    } exp_t;

    exp_t        exp_q[$];
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;
    bit          monitor_on = 1'b0;
    bit [NB-1:0] model = '0;
    bit [1:0]    model_mode = 2'b00;

    function automatic bit [31:0] prime_of(int h);
        bit [31:0] tbl [8] = '{32'h9E3779B1, 32'h85EBCA77, 32'hC2B2AE3D, 32'h27D4EB2F,
                               32'h165667B1, 32'h01000193, 32'h3B9ACA07, 32'h3B800001};
        return tbl[h];
    endfunction

    function automatic bit [NB-1:0] key_mask(bit [31:0] k);
        bit [NB-1:0] m = '0;
        for (int h = 0; h < NH; h++) begin
            bit [31:0] p;
            p = k * prime_of(h);
            m[p >> (32 - IW)] = 1'b1;
        end
        return m;
    endfunction

    function automatic bit snoop_hits(bit [1:0] md, bit v, bit wr);
        return v && ((md == 2'b11) || (md == 2'b01 && !wr) || (md == 2'b10 && wr));
    endfunction

    task automatic check(bit cond, string req, string what, int act, int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus at a falling edge, update the model.
    task automatic step(bit cv, bit [1:0] op, bit [31:0] key,
                        bit sv, bit sw, bit [31:0] sa, string req);
        bit [NB-1:0] cm;
        cmd_valid = cv; cmd_op = op; cmd_key = key;
        snp_valid = sv; snp_write = sw; snp_addr = sa;
        cm = key_mask(key);
        if (cv && op == 2'b01) begin
            exp_t e;
            e.maybe = ((model & cm) == cm);
            e.req   = req;
            exp_q.push_back(e);
        end
        if (cv && op == 2'b10) begin
            model = '0;
        end else begin
            if (cv && op == 2'b00) model |= cm;
            if (snoop_hits(model_mode, sv, sw)) model |= key_mask(sa);
        end
        if (cv && op == 2'b11) model_mode = key[1:0];
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b0, 2'b00, 32'h0, 1'b0, 1'b0, 32'h0, "");
    endtask

    task automatic search(bit [31:0] k, string req);
        step(1'b1, 2'b01, k, 1'b0, 1'b0, 32'h0, req);
    endtask

    // Monitor: answers are due one edge after the search.
    always @(negedge clk) begin
        if (monitor_on && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4", "unexpected rsp_valid", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rsp_maybe == e.maybe, e.req, "rsp_maybe", rsp_maybe, e.maybe);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state; R11: always ready
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
        check(cmd_ready == 1'b1, "R11", "cmd_ready", cmd_ready, 1);
        monitor_on = 1'b1;
        search(32'h0000_1234, "R1");
        // R1: snoop off by default, write snooped but must not be learned
        step(1'b0, 2'b00, 32'h0, 1'b1, 1'b1, 32'h0000_ABCD, "");
        step(1'b0, 2'b00, 32'h0, 1'b1, 1'b0, 32'h0000_ABCD, "");
        search(32'h0000_ABCD, "R1");
        // R3 / R4: insert then search, back-to-back searches
        step(1'b1, 2'b00, 32'hDEAD_BEEF, 1'b0, 1'b0, 32'h0, "");
        search(32'hDEAD_BEEF, "R3");
        search(32'hCAFE_F00D, "R4");
        search(32'hDEAD_BEEF, "R4");
        idle();
        check(rsp_valid == 1'b0, "R4", "rsp_valid pulse ended", rsp_valid, 0);
        check(cmd_ready == 1'b1, "R11", "cmd_ready", cmd_ready, 1);
        // R6 / R7: reads only
        step(1'b1, 2'b11, 32'h1, 1'b0, 1'b0, 32'h0, "");
        step(1'b0, 2'b00, 32'h0, 1'b1, 1'b0, 32'h1000_0040, "");
        step(1'b0, 2'b00, 32'h0, 1'b1, 1'b1, 32'h1000_0080, "");
        search(32'h1000_0040, "R7");
        search(32'h1000_0080, "R7");
        // R6 / R7: writes only
        step(1'b1, 2'b11, 32'h2, 1'b0, 1'b0, 32'h0, "");
        step(1'b0, 2'b00, 32'h0, 1'b1, 1'b0, 32'h2000_0100, "");
        step(1'b0, 2'b00, 32'h0, 1'b1, 1'b1, 32'h2000_0200, "");
        search(32'h2000_0100, "R7");
        search(32'h2000_0200, "R7");
        // R6: both, then off again; config snoop in same cycle uses old mode
        step(1'b1, 2'b11, 32'h3, 1'b1, 1'b1, 32'h3000_0010, "");
        step(1'b0, 2'b00, 32'h0, 1'b1, 1'b0, 32'h3000_0020, "");
        step(1'b0, 2'b00, 32'h0, 1'b1, 1'b1, 32'h3000_0030, "");
        search(32'h3000_0010, "R6");
        search(32'h3000_0020, "R6");
        search(32'h3000_0030, "R6");
        step(1'b1, 2'b11, 32'h0, 1'b0, 1'b0, 32'h0, "");
        step(1'b0, 2'b00, 32'h0, 1'b1, 1'b1, 32'h4000_0040, "");
        search(32'h4000_0040, "R6");
        // R8: command and snoop insert together
        step(1'b1, 2'b11, 32'h3, 1'b0, 1'b0, 32'h0, "");
        step(1'b1, 2'b00, 32'h5555_0001, 1'b1, 1'b0, 32'h6666_0002, "");
        search(32'h5555_0001, "R8");
        search(32'h6666_0002, "R8");
        // R9: search sees pre-insert state
        step(1'b1, 2'b01, 32'h7777_0003, 1'b1, 1'b1, 32'h7777_0003, "R9");
        search(32'h7777_0003, "R9");
        // R10 / R5: clear beats a simultaneous snoop insert
        step(1'b1, 2'b10, 32'h0, 1'b1, 1'b1, 32'h8888_0004, "");
        search(32'h8888_0004, "R10");
        search(32'hDEAD_BEEF, "R5");
        search(32'h5555_0001, "R5");
        // R2: many keys, exact index formula shows in collisions
        for (int i = 0; i < 24; i++) begin
            step(1'b1, 2'b00, 32'h0001_0000 * i + 32'h11 * i, 1'b0, 1'b0, 32'h0, "");
        end
        for (int i = 0; i < 48; i++) begin
            search(32'h0001_0000 * i + 32'h11 * i + ((i % 2) * 32'h0F0F_0003), "R2");
        end
        idle();
        idle();
        check(exp_q.size() == 0, "R4", "answers outstanding", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule